// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block is a small data cache placed between a word-addressed processor port and a main-memory port. It holds 64 words as four lines of 16 words. Each line has its own tag, valid bit and dirty bit. A read hit returns its word combinationally in the cycle the request is accepted. A miss moves the whole 16-word block between the cache and memory. Writes stay in the cache and mark the line dirty. A dirty line is copied back to memory only when another block displaces it.

The processor side uses a valid/ready request channel. A requester raises `cpu_req_valid` and keeps the address, write enable and write data unchanged until it sees `cpu_req_ready` high at a clock edge. The cache gives `cpu_req_ready` only in a cycle where it can serve the access at once, so back-pressure is simply ready held low while a line moves. The memory side is a word-wide request/acknowledge port: a beat is held until `mem_ack`, and one beat completes per acknowledged cycle. A DMA agent that overwrote a memory block pulses `inv_valid` with that block number. If the block is cached, the line is dropped and any dirty words in it are thrown away.

Top module: `dmc_cache_top`

## Requirements
- R1: A word address splits into tag = addr[7:6], line index = addr[5:4] and word offset = addr[3:0]. A lookup hits only when the indexed line is valid and its stored tag equals the address tag. On a read hit, ready is high and `cpu_rsp_rdata` carries the word in the same cycle the request is first presented.
- R2: After reset every line is invalid and clean. The first access to any address is a miss that causes no write-back, and with no request pending, ready and `mem_req` are low.
- R3: `cpu_req_ready` is high only while `cpu_req_valid` is high. An access completes in the cycle where both are high, and the requester holds its request stable until then.
- R4: A write hit updates only the cached word and marks the line dirty, with no memory beat. A later read of that word returns the written value.
- R5: A miss on a clean or invalid line makes 16 read beats (`mem_we`=0) at addresses {tag, index, offset} with offsets 0 to 15 in ascending order. Ready stays low from the cycle of detection until the fill completes, and the access is then served from the filled line. With `mem_ack` high in every cycle, ready rises in the 18th cycle of the request (17 stall cycles).
- R6: A miss on a valid dirty line first writes the old block's 16 words to memory at their own addresses (`mem_we`=1, offsets ascending), then fetches the new block. With `mem_ack` high in every cycle there are 33 stall cycles.
- R7: Each memory beat keeps its request, direction and address until `mem_ack`. The word offset advances by one only on an acknowledged beat.
- R8: An invalidate whose block is currently cached clears that line's valid and dirty bits. The dirty words are discarded and never written back, and the next access to the block misses and returns memory's current contents.
- R9: An invalidate whose block is not cached (a different tag on that line, or an invalid line) has no effect: an access to the block that is cached still hits.
- R10: When an invalidate and a processor lookup target the same cached block in the same cycle, the invalidate wins. The lookup is treated as a miss, with no write-back even if the line was dirty, and the fresh block is fetched.
- R11: An invalidate that names the block being filled while the fill is in progress leaves the line invalid at the end of the fill. The pending access then misses again and fetches the block once more (34 stall cycles with full-speed acknowledge).
- R12: An invalidate for one line does not disturb a hit on a different line in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Request accepted this cycle |
| cpu_req_we | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | 8 | Word address |
| cpu_req_wdata | input | 16 | Write data |
| cpu_rsp_rdata | output | 16 | Read data, meaningful when ready is high on a read |
| mem_req | output | 1 | Memory beat requested |
| mem_we | output | 1 | 1 = write-back beat, 0 = fill beat |
| mem_addr | output | 8 | Memory word address of the beat |
| mem_wdata | output | 16 | Write-back data |
| mem_ack | input | 1 | Memory completes the beat at this edge |
| mem_rdata | input | 16 | Fill data, valid while mem_ack is high |
| inv_valid | input | 1 | DMA invalidate pulse |
| inv_addr | input | 4 | Block number (address bits 7:4) to invalidate |

## Verification
A DMA invalidate and a processor lookup can fall in the same clock cycle, either on the same block or on different lines. The bench provokes this by raising `inv_valid` in the very cycle a request is first presented. For a hit on a dirty block it expects a clean refill with no write beat and the DMA-written data. For a different line it expects an undisturbed zero-stall hit. A second collision puts the invalidate in the middle of a fill of the same block. That case is judged by the doubled stall count, the 32 read beats and the returned data.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WBACK = 2'd1,
    ST_FILL  = 2'd2
  } dmc_state_e;
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
  parameter int TAG_W   = 2,
  parameter int INDEX_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INDEX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0]   lk_tag,
  output logic               lk_hit,
  output logic               lk_victim_dirty,
  output logic [TAG_W-1:0]   lk_victim_tag,
  input  logic               inv_valid,
  input  logic [INDEX_W-1:0] inv_idx,
  input  logic [TAG_W-1:0]   inv_tag,
  input  logic               alloc_en,
  input  logic [INDEX_W-1:0] alloc_idx,
  input  logic [TAG_W-1:0]   alloc_tag,
  input  logic               fill_done,
  input  logic               fill_kill,
  input  logic               mark_dirty
);
  localparam int LINES = 1 << INDEX_W;

  logic [LINES-1:0] valid_q, dirty_q;
  logic [TAG_W-1:0] tag_q [LINES];
  logic             inv_match, inv_on_lookup;

  assign inv_match     = inv_valid && valid_q[inv_idx] && (tag_q[inv_idx] == inv_tag);
  assign inv_on_lookup = inv_match && (inv_idx == lk_idx);

  // an invalidate on the looked-up line wins over the lookup
  assign lk_hit          = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag) && !inv_on_lookup;
  assign lk_victim_dirty = valid_q[lk_idx] && dirty_q[lk_idx] && !inv_on_lookup;
  assign lk_victim_tag   = tag_q[lk_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
      for (int i = 0; i < LINES; i++) tag_q[i] <= '0;
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (alloc_en && alloc_idx == INDEX_W'(i)) begin
          valid_q[i] <= 1'b0;
          dirty_q[i] <= 1'b0;
          tag_q[i]   <= alloc_tag;
        end else if (fill_done && alloc_idx == INDEX_W'(i)) begin
          valid_q[i] <= !fill_kill;
        end else if (inv_match && inv_idx == INDEX_W'(i)) begin
          valid_q[i] <= 1'b0;
          dirty_q[i] <= 1'b0;
        end else if (mark_dirty && lk_idx == INDEX_W'(i)) begin
          dirty_q[i] <= 1'b1;
        end
      end
    end
  end

  // R8
  inv_clears_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_match |=> !valid_q[$past(inv_idx)] && !dirty_q[$past(inv_idx)]);

  // R4
  write_hit_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_dirty && lk_hit) |=> dirty_q[$past(lk_idx)]);

  // R10
  inv_beats_lookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_on_lookup |-> !lk_hit && !lk_victim_dirty);
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
  parameter int DATA_W = 16,
  parameter int WADDR_W = 6
) (
  input  logic               clk,
  input  logic               we,
  input  logic [WADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [WADDR_W-1:0] raddr,
  output logic [DATA_W-1:0]  rdata
);
  localparam int WORDS = 1 << WADDR_W;

  logic [DATA_W-1:0] ram [WORDS];

  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
  end

  assign rdata = ram[raddr];
endmodule

// File: rtl/dmc_sequencer.sv
module dmc_sequencer
  import dmc_pkg::*;
#(
  parameter int TAG_W    = 2,
  parameter int INDEX_W  = 2,
  parameter int OFFSET_W = 4,
  parameter int ADDR_W   = TAG_W + INDEX_W + OFFSET_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpu_valid,
  input  logic                cpu_we,
  input  logic [INDEX_W-1:0]  cpu_idx,
  input  logic [TAG_W-1:0]    cpu_tag,
  input  logic                lk_hit,
  input  logic                lk_victim_dirty,
  input  logic [TAG_W-1:0]    lk_victim_tag,
  input  logic                inv_valid,
  input  logic [INDEX_W-1:0]  inv_idx,
  input  logic [TAG_W-1:0]    inv_tag,
  input  logic                mem_ack,
  output logic                cpu_ready,
  output logic                mark_dirty,
  output logic                alloc_en,
  output logic [INDEX_W-1:0]  line_idx,
  output logic                fill_done,
  output logic                fill_kill,
  output logic                fill_wr,
  output logic                wb_active,
  output logic [OFFSET_W-1:0] beat,
  output logic                mem_req,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr
);
  localparam logic [OFFSET_W-1:0] LAST = {OFFSET_W{1'b1}};

  dmc_state_e          st_q, st_d;
  logic [OFFSET_W-1:0] beat_q;
  logic [INDEX_W-1:0]  idx_q;
  logic [TAG_W-1:0]    new_tag_q, old_tag_q;
  logic                kill_q, inv_on_fill, idle;

  assign idle        = (st_q == ST_IDLE);
  assign inv_on_fill = inv_valid && (inv_idx == idx_q) && (inv_tag == new_tag_q);

  assign cpu_ready  = idle && cpu_valid && lk_hit;
  assign mark_dirty = cpu_ready && cpu_we;
  assign alloc_en   = idle && cpu_valid && !lk_hit;
  assign line_idx   = idle ? cpu_idx : idx_q;
  assign wb_active  = (st_q == ST_WBACK);
  assign fill_wr    = (st_q == ST_FILL) && mem_ack;
  assign fill_done  = fill_wr && (beat_q == LAST);
  assign fill_kill  = kill_q || inv_on_fill;
  assign beat       = beat_q;
  assign mem_req    = !idle;
  assign mem_we     = wb_active;
  assign mem_addr   = {(wb_active ? old_tag_q : new_tag_q), idx_q, beat_q};

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (alloc_en) st_d = lk_victim_dirty ? ST_WBACK : ST_FILL;
      ST_WBACK: if (mem_ack && beat_q == LAST) st_d = ST_FILL;
      ST_FILL:  if (mem_ack && beat_q == LAST) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      beat_q    <= '0;
      idx_q     <= '0;
      new_tag_q <= '0;
      old_tag_q <= '0;
      kill_q    <= 1'b0;
    end else begin
      st_q <= st_d;
      if (alloc_en) begin
        idx_q     <= cpu_idx;
        new_tag_q <= cpu_tag;
        old_tag_q <= lk_victim_tag;
        beat_q    <= '0;
        kill_q    <= 1'b0;
      end else if (!idle) begin
        if (mem_ack) beat_q <= beat_q + 1'b1;
        if (st_q == ST_FILL && inv_on_fill) kill_q <= 1'b1;
      end
    end
  end

  // R3
  ready_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> cpu_valid);

  // R5
  no_ready_in_transfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |-> !cpu_ready);

  // R6
  wback_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_active && mem_ack && beat_q == LAST) |=> (st_q == ST_FILL) && mem_req && !mem_we);

  // R7
  beat_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && beat_q != LAST) |=> mem_req && (beat_q == OFFSET_W'($past(beat_q) + 1'b1)));

  // R7
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr) && $stable(mem_we));
endmodule

// File: rtl/dmc_cache_top.sv
module dmc_cache_top #(
  parameter int DATA_W   = 16,
  parameter int TAG_W    = 2,
  parameter int INDEX_W  = 2,
  parameter int OFFSET_W = 4,
  parameter int ADDR_W   = TAG_W + INDEX_W + OFFSET_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cpu_req_valid,
  output logic                       cpu_req_ready,
  input  logic                       cpu_req_we,
  input  logic [ADDR_W-1:0]          cpu_req_addr,
  input  logic [DATA_W-1:0]          cpu_req_wdata,
  output logic [DATA_W-1:0]          cpu_rsp_rdata,
  output logic                       mem_req,
  output logic                       mem_we,
  output logic [ADDR_W-1:0]          mem_addr,
  output logic [DATA_W-1:0]          mem_wdata,
  input  logic                       mem_ack,
  input  logic [DATA_W-1:0]          mem_rdata,
  input  logic                       inv_valid,
  input  logic [TAG_W+INDEX_W-1:0]   inv_addr
);
  localparam int WADDR_W = INDEX_W + OFFSET_W;

  logic [TAG_W-1:0]    cpu_tag, inv_tag, victim_tag;
  logic [INDEX_W-1:0]  cpu_idx, inv_idx, line_idx;
  logic [OFFSET_W-1:0] cpu_off, beat;
  logic                hit, victim_dirty, mark_dirty, alloc_en;
  logic                fill_done, fill_kill, fill_wr, wb_active;
  logic                ds_we;
  logic [WADDR_W-1:0]  ds_waddr, ds_raddr;
  logic [DATA_W-1:0]   ds_wdata, ds_rdata;

  assign cpu_tag = cpu_req_addr[ADDR_W-1 -: TAG_W];
  assign cpu_idx = cpu_req_addr[OFFSET_W +: INDEX_W];
  assign cpu_off = cpu_req_addr[OFFSET_W-1:0];
  assign inv_tag = inv_addr[TAG_W+INDEX_W-1 -: TAG_W];
  assign inv_idx = inv_addr[INDEX_W-1:0];

  dmc_tag_store #(.TAG_W(TAG_W), .INDEX_W(INDEX_W)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .lk_idx(cpu_idx), .lk_tag(cpu_tag),
    .lk_hit(hit), .lk_victim_dirty(victim_dirty), .lk_victim_tag(victim_tag),
    .inv_valid(inv_valid), .inv_idx(inv_idx), .inv_tag(inv_tag),
    .alloc_en(alloc_en), .alloc_idx(line_idx), .alloc_tag(cpu_tag),
    .fill_done(fill_done), .fill_kill(fill_kill), .mark_dirty(mark_dirty)
  );

  dmc_sequencer #(.TAG_W(TAG_W), .INDEX_W(INDEX_W), .OFFSET_W(OFFSET_W), .ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_req_valid), .cpu_we(cpu_req_we), .cpu_idx(cpu_idx), .cpu_tag(cpu_tag),
    .lk_hit(hit), .lk_victim_dirty(victim_dirty), .lk_victim_tag(victim_tag),
    .inv_valid(inv_valid), .inv_idx(inv_idx), .inv_tag(inv_tag),
    .mem_ack(mem_ack),
    .cpu_ready(cpu_req_ready), .mark_dirty(mark_dirty), .alloc_en(alloc_en),
    .line_idx(line_idx), .fill_done(fill_done), .fill_kill(fill_kill), .fill_wr(fill_wr),
    .wb_active(wb_active), .beat(beat),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr)
  );

  assign ds_we    = mark_dirty || fill_wr;
  assign ds_waddr = fill_wr ? {line_idx, beat} : {cpu_idx, cpu_off};
  assign ds_wdata = fill_wr ? mem_rdata : cpu_req_wdata;
  assign ds_raddr = wb_active ? {line_idx, beat} : {cpu_idx, cpu_off};

  dmc_data_store #(.DATA_W(DATA_W), .WADDR_W(WADDR_W)) u_data (
    .clk(clk), .we(ds_we), .waddr(ds_waddr), .wdata(ds_wdata),
    .raddr(ds_raddr), .rdata(ds_rdata)
  );

  assign mem_wdata     = ds_rdata;
  assign cpu_rsp_rdata = ds_rdata;
endmodule

// File: tb/dmc_cache_top_tb.sv
`timescale 1ns/1ps
module dmc_cache_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req_valid = 1'b0, cpu_req_we = 1'b0;
  logic        cpu_req_ready;
  logic [7:0]  cpu_req_addr = '0;
  logic [15:0] cpu_req_wdata = '0, cpu_rsp_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [7:0]  mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic        inv_valid = 1'b0;
  logic [3:0]  inv_addr = '0;

  always #2.5 clk = ~clk;

  dmc_cache_top u_dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready), .cpu_req_we(cpu_req_we),
    .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata), .cpu_rsp_rdata(cpu_rsp_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .inv_valid(inv_valid), .inv_addr(inv_addr)
  );

  // behavioural memory, CPU-visible image and cache bookkeeping
  logic [15:0] phys [256];
  logic [15:0] golden [256];
  bit          mvalid [4];
  bit          mdirty [4];
  int          mtag [4];
  int          n_tests = 0, n_fail = 0, dma_seed = 0;
  int          rd_beats, wr_beats, exp_off = 0;
  bit          seen_rd, slow_ack = 1'b0, ack_gate = 1'b1, done = 1'b0;

  assign mem_ack   = mem_req && ack_gate;
  assign mem_rdata = phys[mem_addr];

  always @(posedge clk) begin
    ack_gate <= slow_ack ? ~ack_gate : 1'b1;
    if (mem_req && mem_ack && mem_we) phys[mem_addr] <= mem_wdata;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // per-clock monitor
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (cpu_req_ready) chk(cpu_req_valid, "R3", "ready without valid", 1, 0);
      if (mem_req && mem_ack) begin
        chk(mem_addr[3:0] == exp_off[3:0], "R7", "beat offset", mem_addr[3:0], exp_off[3:0]);
        exp_off = (exp_off + 1) % 16;
        if (mem_we) begin
          wr_beats++;
          chk(!seen_rd, "R6", "write-back after fill", 1, 0);
          chk(mem_wdata == golden[mem_addr], "R6", "write-back data", mem_wdata, golden[mem_addr]);
        end else begin
          rd_beats++;
          seen_rd = 1'b1;
        end
      end
    end
  end

  task automatic dma_apply(input logic [3:0] blk);
    for (int w = 0; w < 16; w++) begin
      phys[{blk, 4'(w)}]   = 16'hD000 ^ 16'(dma_seed * 16 + w);
      golden[{blk, 4'(w)}] = 16'hD000 ^ 16'(dma_seed * 16 + w);
    end
    dma_seed++;
    if (mvalid[blk[1:0]] && mtag[blk[1:0]] == int'(blk[3:2])) begin
      mvalid[blk[1:0]] = 1'b0;
      mdirty[blk[1:0]] = 1'b0;
    end
  endtask

  task automatic dma_inv(input logic [3:0] blk);
    @(negedge clk);
    dma_apply(blk);
    inv_valid = 1'b1;
    inv_addr  = blk;
    @(negedge clk);
    inv_valid = 1'b0;
  endtask

  task automatic access(input bit we, input logic [7:0] addr, input logic [15:0] wd,
                        input bit inv_now, input logic [3:0] inv_blk, input bit inv_mid,
                        input bit chk_stall, input string req);
    int idx, tg, exp_stall, exp_rd, exp_wr, stall;
    bit hit;
    idx = int'(addr[5:4]);
    tg  = int'(addr[7:6]);
    @(negedge clk);
    if (inv_now) begin
      dma_apply(inv_blk);
      inv_valid = 1'b1;
      inv_addr  = inv_blk;
    end
    hit       = mvalid[idx] && mtag[idx] == tg;
    exp_wr    = (!hit && mvalid[idx] && mdirty[idx]) ? 16 : 0;
    exp_rd    = hit ? 0 : 16;
    exp_stall = hit ? 0 : (exp_wr != 0 ? 33 : 17);
    if (inv_mid) begin
      exp_stall += 17;
      exp_rd    += 16;
    end
    rd_beats = 0; wr_beats = 0; seen_rd = 1'b0;
    cpu_req_valid = 1'b1; cpu_req_we = we; cpu_req_addr = addr; cpu_req_wdata = wd;
    stall = 0;
    forever begin
      #1;
      if (cpu_req_ready) break;
      stall++;
      if (stall > 200) break;
      @(negedge clk);
      inv_valid = 1'b0;
      if (inv_mid && stall == 5) begin
        dma_apply(addr[7:4]);
        inv_valid = 1'b1;
        inv_addr  = addr[7:4];
      end
    end
    if (!we) chk(cpu_rsp_rdata == golden[addr], req, "read data", cpu_rsp_rdata, golden[addr]);
    if (chk_stall) chk(stall == exp_stall, req, "stall cycles", stall, exp_stall);
    chk(rd_beats == exp_rd, req, "fill beats", rd_beats, exp_rd);
    chk(wr_beats == exp_wr, req, "write-back beats", wr_beats, exp_wr);
    if (!hit) begin
      mvalid[idx] = 1'b1; mtag[idx] = tg; mdirty[idx] = 1'b0;
    end
    if (we) begin
      golden[addr] = wd;
      mdirty[idx] = 1'b1;
    end
    @(posedge clk);
    @(negedge clk);
    cpu_req_valid = 1'b0;
    inv_valid = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      phys[i]   = 16'h1000 + 16'(i * 3);
      golden[i] = 16'h1000 + 16'(i * 3);
    end
    for (int i = 0; i < 4; i++) begin
      mvalid[i] = 1'b0; mdirty[i] = 1'b0; mtag[i] = 0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R2 reset state
    chk(!mem_req, "R2", "mem_req after reset", mem_req, 0);
    chk(!cpu_req_ready, "R2", "ready after reset", cpu_req_ready, 0);

    access(0, 8'h00, 0, 0, 0, 0, 1, "R2 first miss");
    access(0, 8'h05, 0, 0, 0, 0, 1, "R1 read hit");
    access(0, 8'h4F, 0, 0, 0, 0, 1, "R5 clean replace");
    access(0, 8'h13, 0, 0, 0, 0, 1, "R5 miss idx1");
    access(1, 8'h14, 16'hBEEF, 0, 0, 0, 1, "R4 write hit");
    access(0, 8'h14, 0, 0, 0, 0, 1, "R4 read back");
    access(0, 8'h94, 0, 0, 0, 0, 1, "R6 dirty evict");
    access(0, 8'h14, 0, 0, 0, 0, 1, "R6 written back");
    access(1, 8'h22, 16'h1234, 0, 0, 0, 1, "R5 write miss");
    dma_inv(4'h2);
    access(0, 8'h22, 0, 0, 0, 0, 1, "R8 invalidated dirty");
    dma_inv(4'hE);
    access(0, 8'h21, 0, 0, 0, 0, 1, "R9 foreign tag");
    dma_inv(4'hF);
    access(0, 8'h14, 0, 0, 0, 0, 1, "R9 invalid line");
    access(1, 8'h25, 16'h5A5A, 0, 0, 0, 1, "R4 dirty again");
    access(0, 8'h25, 0, 1, 4'h2, 0, 1, "R10 same-cycle invalidate");
    access(0, 8'h26, 0, 1, 4'h4, 0, 1, "R12 other-line invalidate");
    access(0, 8'h41, 0, 0, 0, 0, 1, "R12 line dropped");
    access(0, 8'hC8, 0, 0, 0, 1, 1, "R11 invalidate during fill");
    slow_ack = 1'b1;
    access(1, 8'hC9, 16'h0F0F, 0, 0, 0, 1, "R4 slow hit");
    access(0, 8'h09, 0, 0, 0, 0, 0, "R7 slow dirty evict");
    access(0, 8'hC9, 0, 0, 0, 0, 0, "R7 slow refetch");
    slow_ack = 1'b0;
    for (int k = 0; k < 40; k++)
      access(k % 3 == 0, 8'((k * 53 + 7) % 256), 16'hA000 + 16'(k), 0, 0, 0, 1, "R1 R5 R6 sweep");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule